// File: doc/BRIEF.md
# Operand address derivation unit

This unit turns the addressing fields of one instruction into a derived address and a derived operand for a 16-bit machine whose memory is addressed in 16-bit words. Decode presents a mode code and the raw fields: two register numbers with the values already read for them, a 4-bit short immediate, an 8-bit displacement, the 16-bit address/immediate word and the current instruction counter. The unit works out the address, fetches the operand from memory when the mode calls for it, and reports the result with a one-cycle done strobe.

Memory modes issue one word read at the derived address. The two indirect modes first read a pointer word, which becomes the derived address, and then read the operand. Reads use a request/acknowledge handshake that tolerates any number of wait cycles. Register, immediate and branch-target modes need no memory and finish in the cycle after acceptance. A new request is only taken while `ready_o` is high.

Top module: `oau_top`

## Requirements
- R1: After reset, ready_o is 1, done_o and mem_req_o are 0, and dadr_o and dopnd_o are 0.
- R2: Mode 0 (register) returns ra_val_i as operand, reports the register number ra_sel_i zero-extended as the address, and makes no memory read.
- R3: Mode 1 (direct) uses word_i as address; mode 2 (indexed direct) uses word_i plus the index value, wrapping modulo 2^16. The operand is the memory word read at that address.
- R4: An index field rx_sel_i of 0 means no indexing, whatever rx_val_i holds, in modes 2, 4, 5 and 10.
- R5: Mode 3 (indirect) reads the pointer at word_i, mode 4 (pre-indexed indirect) at word_i plus index; the word read is the derived address, and a second read there returns the operand.
- R6: Mode 5 (long immediate) returns word_i plus the index value as operand, address 0, no memory read.
- R7: Mode 6 returns imm_i+1 (1 to 16); mode 7 returns the 16-bit two's complement of imm_i+1; both report address 0 and read no memory.
- R8: Mode 8 (counter-relative) reports ic_i minus 1 plus the sign-extended displacement as address, operand 0, no memory read.
- R9: Mode 9 (base-relative) uses ra_val_i plus the zero-extended displacement as address; mode 10 (base-indexed) uses ra_val_i plus the index value; the operand is read at that address.
- R10: done_o is high for exactly one cycle: in the cycle after acceptance for non-memory modes, and in the cycle after the acknowledge of the last read otherwise; a read whose acknowledge comes w cycles after its request starts adds w+1 cycles.
- R11: mem_req_o keeps mem_addr_o stable until mem_ack_i; each acknowledge completes exactly one read (one read for modes 1, 2, 9, 10; two for modes 3, 4).
- R12: req_i is accepted only while ready_o is high; a request raised while busy is ignored and produces no second result.
- R13: Codes 11 to 15 are reserved and complete like non-memory modes with address 0 and operand 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a derivation; fields sampled on acceptance |
| ready_o | output | 1 | Unit idle, req_i will be accepted |
| mode_i | input | 4 | Addressing mode code |
| ra_sel_i | input | 4 | Register / base register number |
| ra_val_i | input | 16 | Value of register ra_sel_i |
| rx_sel_i | input | 4 | Index register number, 0 = none |
| rx_val_i | input | 16 | Value of register rx_sel_i |
| imm_i | input | 4 | Short immediate field |
| disp_i | input | 8 | Displacement field |
| word_i | input | 16 | Address or long immediate word |
| ic_i | input | 16 | Instruction counter (one past current instruction) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Read data valid, request complete |
| mem_rdata_i | input | 16 | Read data |
| done_o | output | 1 | One-cycle result strobe |
| dadr_o | output | 16 | Derived address |
| dopnd_o | output | 16 | Derived operand |

## Verification
Non-memory modes report on the first falling edge after the accepting rising edge, and each read adds its wait count plus one cycle, so the expected delay is 1 + reads × (wait + 1). The bench counts falling edges from acceptance until done and compares that count with the expected delay, varying the memory wait per vector, and samples results only at that edge. It also checks that done is low one cycle later and counts acknowledged reads per request.

// File: rtl/oau_pkg.sv
package oau_pkg;
  typedef enum logic [3:0] {
    M_REG  = 4'd0,
    M_DIR  = 4'd1,
    M_DIRX = 4'd2,
    M_IND  = 4'd3,
    M_INDX = 4'd4,
    M_IMML = 4'd5,
    M_ISP  = 4'd6,
    M_ISN  = 4'd7,
    M_ICR  = 4'd8,
    M_BREL = 4'd9,
    M_BIDX = 4'd10,
    M_R11  = 4'd11,
    M_R12  = 4'd12,
    M_R13  = 4'd13,
    M_R14  = 4'd14,
    M_R15  = 4'd15
  } mode_e;

  // memory accesses needed per mode
  typedef enum logic [1:0] {ACC_NONE, ACC_ONE, ACC_TWO} acc_e;

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_OPND, S_DONE} st_e;
endpackage

// File: rtl/oau_calc.sv
module oau_calc
  import oau_pkg::*;
#(
  parameter int DW    = 16,
  parameter int RW    = 4,
  parameter int IMMW  = 4,
  parameter int DISPW = 8
) (
  input  mode_e           mode_i,
  input  logic [RW-1:0]   ra_sel_i,
  input  logic [DW-1:0]   ra_val_i,
  input  logic [RW-1:0]   rx_sel_i,
  input  logic [DW-1:0]   rx_val_i,
  input  logic [IMMW-1:0] imm_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [DW-1:0]   word_i,
  input  logic [DW-1:0]   ic_i,
  output logic [DW-1:0]   first_addr_o,
  output logic [DW-1:0]   imm_opnd_o,
  output acc_e            acc_o
);
  localparam int DPADW = DW - DISPW;
  localparam int IPADW = DW - IMMW;
  localparam int RPADW = DW - RW;

  logic [DW-1:0] idx, disp_s, disp_u, mag, cur_pc, xword;

  always_comb begin
    idx    = (rx_sel_i != '0) ? rx_val_i : '0;  // R0 = no index
    disp_s = {{DPADW{disp_i[DISPW-1]}}, disp_i};
    disp_u = {{DPADW{1'b0}}, disp_i};
    mag    = {{IPADW{1'b0}}, imm_i} + DW'(1);
    cur_pc = ic_i - DW'(1);
    xword  = word_i + idx;
  end

  always_comb begin
    first_addr_o = '0;
    imm_opnd_o   = '0;
    acc_o        = ACC_NONE;
    unique case (mode_i)
      M_REG: begin
        first_addr_o = {{RPADW{1'b0}}, ra_sel_i};
        imm_opnd_o   = ra_val_i;
      end
      M_DIR: begin
        first_addr_o = word_i;
        acc_o        = ACC_ONE;
      end
      M_DIRX: begin
        first_addr_o = xword;
        acc_o        = ACC_ONE;
      end
      M_IND: begin
        first_addr_o = word_i;
        acc_o        = ACC_TWO;
      end
      M_INDX: begin
        first_addr_o = xword;
        acc_o        = ACC_TWO;
      end
      M_IMML: imm_opnd_o = xword;
      M_ISP:  imm_opnd_o = mag;
      M_ISN:  imm_opnd_o = '0 - mag;
      M_ICR:  first_addr_o = cur_pc + disp_s;
      M_BREL: begin
        first_addr_o = ra_val_i + disp_u;
        acc_o        = ACC_ONE;
      end
      M_BIDX: begin
        first_addr_o = ra_val_i + idx;
        acc_o        = ACC_ONE;
      end
      default: begin
        first_addr_o = '0;
        imm_opnd_o   = '0;
        acc_o        = ACC_NONE;
      end
    endcase
  end
endmodule

// File: rtl/oau_seq.sv
module oau_seq
  import oau_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  mode_e         mode_i,
  input  logic [DW-1:0] first_addr_i,
  input  logic [DW-1:0] imm_opnd_i,
  input  acc_e          acc_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic [DW-1:0] dadr_o,
  output logic [DW-1:0] dopnd_o
);
  st_e           st_q;
  mode_e         mode_q;
  logic [DW-1:0] addr_q, opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= M_REG;
      addr_q <= '0;
      opnd_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          mode_q <= mode_i;
          addr_q <= first_addr_i;
          opnd_q <= imm_opnd_i;
          unique case (acc_i)
            ACC_TWO: st_q <= S_PTR;
            ACC_ONE: st_q <= S_OPND;
            default: st_q <= S_DONE;
          endcase
        end
        S_PTR: if (mem_ack_i) begin
          addr_q <= mem_rdata_i;  // pointer becomes derived address
          st_q   <= S_OPND;
        end
        S_OPND: if (mem_ack_i) begin
          opnd_q <= mem_rdata_i;
          st_q   <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o    = (st_q == S_IDLE);
  assign done_o     = (st_q == S_DONE);
  assign mem_req_o  = (st_q == S_PTR) || (st_q == S_OPND);
  assign mem_addr_o = addr_q;
  assign dadr_o     = addr_q;
  assign dopnd_o    = opnd_q;

  a_r11_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  a_r12_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o |=> !ready_o);

  a_r7_short_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q == M_ISP |-> dopnd_o >= DW'(1) && dopnd_o <= DW'(16));

  a_r8_icr_opnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q == M_ICR |-> dopnd_o == '0);
endmodule

// File: rtl/oau_top.sv
module oau_top
  import oau_pkg::*;
#(
  parameter int DW    = 16,
  parameter int RW    = 4,
  parameter int IMMW  = 4,
  parameter int DISPW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             ready_o,
  input  logic [3:0]       mode_i,
  input  logic [RW-1:0]    ra_sel_i,
  input  logic [DW-1:0]    ra_val_i,
  input  logic [RW-1:0]    rx_sel_i,
  input  logic [DW-1:0]    rx_val_i,
  input  logic [IMMW-1:0]  imm_i,
  input  logic [DISPW-1:0] disp_i,
  input  logic [DW-1:0]    word_i,
  input  logic [DW-1:0]    ic_i,
  output logic             mem_req_o,
  output logic [DW-1:0]    mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic [DW-1:0]    dadr_o,
  output logic [DW-1:0]    dopnd_o
);
  mode_e         mode;
  acc_e          acc;
  logic [DW-1:0] first_addr, imm_opnd;

  assign mode = mode_e'(mode_i);

  oau_calc #(.DW(DW), .RW(RW), .IMMW(IMMW), .DISPW(DISPW)) u_calc (
    .mode_i      (mode),
    .ra_sel_i    (ra_sel_i),
    .ra_val_i    (ra_val_i),
    .rx_sel_i    (rx_sel_i),
    .rx_val_i    (rx_val_i),
    .imm_i       (imm_i),
    .disp_i      (disp_i),
    .word_i      (word_i),
    .ic_i        (ic_i),
    .first_addr_o(first_addr),
    .imm_opnd_o  (imm_opnd),
    .acc_o       (acc)
  );

  oau_seq #(.DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .ready_o     (ready_o),
    .mode_i      (mode),
    .first_addr_i(first_addr),
    .imm_opnd_i  (imm_opnd),
    .acc_i       (acc),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .dadr_o      (dadr_o),
    .dopnd_o     (dopnd_o)
  );
endmodule

// File: tb/oau_top_test.sv
module oau_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic [3:0]  mode;
    logic [3:0]  rx_sel;
    logic [3:0]  ra_sel;
    logic [3:0]  imm;
    logic [7:0]  disp;
    logic [15:0] word;
    logic [15:0] ic;
    logic [15:0] rx_val;
    logic [15:0] ra_val;
    logic [7:0]  lat;
    logic [3:0]  reads;
    logic [15:0] exp_da;
    logic [15:0] exp_op;
  } vec_t;

  // memory model returns the bitwise inverse of the address
  localparam vec_t VECS [NV] = '{
    '{4'd0,  4'd0, 4'd5, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 8'd0, 4'd0, 16'h0005, 16'h1234}, // R2
    '{4'd1,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd1, 16'h0100, 16'hFEFF}, // R3
    '{4'd2,  4'd3, 4'd0, 4'd0, 8'h00, 16'h0100, 16'h0000, 16'h0010, 16'h0000, 8'd2, 4'd1, 16'h0110, 16'hFEEF}, // R3
    '{4'd2,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0100, 16'h0000, 16'h0777, 16'h0000, 8'd1, 4'd1, 16'h0100, 16'hFEFF}, // R4
    '{4'd2,  4'd1, 4'd0, 4'd0, 8'h00, 16'h0002, 16'h0000, 16'hFFFF, 16'h0000, 8'd0, 4'd1, 16'h0001, 16'hFFFE}, // R3 wrap
    '{4'd3,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0200, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd2, 16'hFDFF, 16'h0200}, // R5
    '{4'd4,  4'd2, 4'd0, 4'd0, 8'h00, 16'h0200, 16'h0000, 16'h0003, 16'h0000, 8'd1, 4'd2, 16'hFDFC, 16'h0203}, // R5
    '{4'd4,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0200, 16'h0000, 16'h0099, 16'h0000, 8'd0, 4'd2, 16'hFDFF, 16'h0200}, // R4
    '{4'd5,  4'd4, 4'd0, 4'd0, 8'h00, 16'h1000, 16'h0000, 16'h0011, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'h1011}, // R6
    '{4'd5,  4'd0, 4'd0, 4'd0, 8'h00, 16'h1000, 16'h0000, 16'h5555, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'h1000}, // R4
    '{4'd6,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'h0001}, // R7
    '{4'd6,  4'd0, 4'd0, 4'hF, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'h0010}, // R7
    '{4'd7,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'hFFFF}, // R7
    '{4'd7,  4'd0, 4'd0, 4'hF, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'hFFF0}, // R7
    '{4'd8,  4'd0, 4'd0, 4'd0, 8'h80, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h007F, 16'h0000}, // R8
    '{4'd8,  4'd0, 4'd0, 4'd0, 8'h7F, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h017E, 16'h0000}, // R8
    '{4'd8,  4'd0, 4'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'hFFFF, 16'h0000}, // R8 wrap
    '{4'd9,  4'd0, 4'd0, 4'd0, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 16'h0100, 8'd0, 4'd1, 16'h01FF, 16'hFE00}, // R9
    '{4'd10, 4'd7, 4'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0034, 16'h2000, 8'd3, 4'd1, 16'h2034, 16'hDFCB}, // R9
    '{4'd10, 4'd0, 4'd0, 4'd0, 8'h00, 16'h0000, 16'h0000, 16'h0034, 16'h2000, 8'd0, 4'd1, 16'h2000, 16'hDFFF}, // R4
    '{4'd15, 4'd1, 4'd2, 4'd3, 8'h44, 16'h5555, 16'h1111, 16'h2222, 16'h3333, 8'd0, 4'd0, 16'h0000, 16'h0000}, // R13
    '{4'd11, 4'd0, 4'd0, 4'd0, 8'h00, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 8'd0, 4'd0, 16'h0000, 16'h0000}  // R13
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0, ra_sel_i = '0, rx_sel_i = '0, imm_i = '0;
  logic [7:0]  disp_i = '0;
  logic [15:0] ra_val_i = '0, rx_val_i = '0, word_i = '0, ic_i = '0;
  logic        ready_o, mem_req_o, mem_ack_i, done_o;
  logic [15:0] mem_addr_o, mem_rdata_i, dadr_o, dopnd_o;

  int unsigned lat_cfg = 0;
  int unsigned wait_cnt = 0;
  int unsigned total_reads = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign mem_ack_i   = mem_req_o && (wait_cnt == lat_cfg);
  assign mem_rdata_i = ~mem_addr_o;

  always @(posedge clk_i) begin
    if (!mem_req_o || mem_ack_i) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;
    if (mem_ack_i) total_reads <= total_reads + 1;
  end

  oau_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
    .mode_i(mode_i), .ra_sel_i(ra_sel_i), .ra_val_i(ra_val_i),
    .rx_sel_i(rx_sel_i), .rx_val_i(rx_val_i), .imm_i(imm_i),
    .disp_i(disp_i), .word_i(word_i), .ic_i(ic_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .done_o(done_o), .dadr_o(dadr_o), .dopnd_o(dopnd_o)
  );

  function automatic string req_of(logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      default: return "R13";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(int i);
    vec_t v = VECS[i];
    int n = 1;
    int unsigned r0;
    @(negedge clk_i);
    mode_i = v.mode; rx_sel_i = v.rx_sel; ra_sel_i = v.ra_sel; imm_i = v.imm;
    disp_i = v.disp; word_i = v.word; ic_i = v.ic; rx_val_i = v.rx_val;
    ra_val_i = v.ra_val; lat_cfg = v.lat; req_i = 1'b1;
    r0 = total_reads;
    @(negedge clk_i);
    req_i = 1'b0;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    check($sformatf("R10 vec%0d latency", i), n, 1 + v.reads * (v.lat + 1));
    check($sformatf("%s vec%0d dadr", req_of(v.mode), i), dadr_o, v.exp_da);
    check($sformatf("%s vec%0d dopnd", req_of(v.mode), i), dopnd_o, v.exp_op);
    check($sformatf("R11 vec%0d reads", i), total_reads - r0, v.reads);
    @(negedge clk_i);
    check($sformatf("R10 vec%0d done one cycle", i), done_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 ready in reset", ready_o, 1);
    check("R1 done in reset", done_o, 0);
    check("R1 mem_req in reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 dadr after reset", dadr_o, 0);
    check("R1 dopnd after reset", dopnd_o, 0);
    check("R1 ready after reset", ready_o, 1);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R12: request while busy is ignored
    begin
      int n = 1;
      int extra = 0;
      @(negedge clk_i);
      mode_i = 4'd1; rx_sel_i = 4'd0; word_i = 16'h0300; lat_cfg = 3; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
      check("R12 busy after accept", ready_o, 0);
      @(negedge clk_i);
      n++;
      mode_i = 4'd6; imm_i = 4'd5; req_i = 1'b1;
      @(negedge clk_i);
      n++;
      req_i = 1'b0;
      while (!done_o && n < 200) begin
        @(negedge clk_i);
        n++;
      end
      check("R10 busy case latency", n, 5);
      check("R12 dadr kept first request", dadr_o, 16'h0300);
      check("R12 dopnd kept first request", dopnd_o, 16'hFCFF);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk_i);
        if (done_o) extra++;
      end
      check("R12 no second result", extra, 0);
      check("R12 ready after completion", ready_o, 1);
      check("R12 dadr unchanged while idle", dadr_o, 16'h0300);
    end

    // R11: long wait on indirect, address held
    begin
      int n = 1;
      logic [15:0] seen;
      @(negedge clk_i);
      mode_i = 4'd3; word_i = 16'h0ABC; lat_cfg = 5; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
      seen = mem_addr_o;
      repeat (3) @(negedge clk_i);
      n += 3;
      check("R11 address held while waiting", mem_addr_o, seen);
      check("R5 pointer read at word", seen, 16'h0ABC);
      while (!done_o && n < 200) begin
        @(negedge clk_i);
        n++;
      end
      check("R10 indirect long wait latency", n, 13);
      check("R5 indirect long wait dadr", dadr_o, 16'hF543);
      check("R5 indirect long wait dopnd", dopnd_o, 16'h0ABC);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule